// File: doc/BRIEF.md
# Framed Configuration Message Receiver

This block sits behind a byte-wide serial receiver and turns a raw byte stream into framed configuration messages. While idle it scans the stream for the start marker 0x3C and discards every other byte. After a start marker it captures a one-byte target selector, a one-byte burst length and a three-byte address. It then forwards each payload byte with a one-cycle strobe and a running ordinal.

A CRC-8 check byte follows the payload, and then an end marker 0xA5. A frame whose check byte and end marker are both correct is confirmed with a one-cycle success pulse. If either one is wrong, a one-cycle failure pulse is raised, the frame is dropped and the block goes back to scanning for a start marker.

A downstream bus master listens to the strobed payload. It commits or discards the work for the message depending on which pulse it sees.

Top module: `cfr_frame_rx`

## Requirements
- R1: After the asynchronous active-low reset, `msg_kind`, `msg_addr`, `pay_byte` and `pay_count` read zero. `pay_valid`, `frame_ok` and `frame_bad` are low, and the block is scanning for a start marker.
- R2: While scanning, an accepted byte (`in_valid` high) other than 0x3C produces no strobe and no pulse. It also leaves `msg_kind` and `msg_addr` unchanged.
- R3: The byte after the start marker appears on `msg_kind` one cycle after it is accepted. The next byte is the length. The three bytes after the length form `msg_addr`, most significant byte first. `msg_addr` holds the full value from the cycle after the third address byte until the next frame's address bytes.
- R4: A length byte of value N announces N+1 payload bytes, so 0x00 announces 1 and 0xFF announces 256. Each payload byte appears on `pay_byte` with `pay_valid` high for exactly one cycle, one cycle after it is accepted. At that point `pay_count` holds its 1-based ordinal.
- R5: The check byte is CRC-8 with polynomial x^8+x^2+x+1 (0x07), initial value 0x00, processed most significant bit first, over the type, length, address and payload bytes. When the check byte matches and the following byte is 0xA5, `frame_ok` pulses for one cycle, in the cycle after the end byte is accepted.
- R6: A check byte that does not match raises `frame_bad` for one cycle, in the cycle after the check byte is accepted. The block then returns to scanning, so a following 0xA5 is ignored.
- R7: A matching check byte followed by an end byte other than 0xA5 raises `frame_bad` for one cycle, in the cycle after that byte is accepted.
- R8: Cycles with `in_valid` low advance nothing: they produce no strobe and no pulse, and parsing resumes with the next accepted byte.
- R9: `frame_ok` and `frame_bad` are never high together, and neither is high in a cycle in which `pay_valid` is high.
- R10: A start marker accepted in the cycle directly after an end byte begins a new frame, so frames may arrive back to back with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte is valid this cycle |
| in_byte | input | 8 | Received byte |
| msg_kind | output | 8 | Captured type (target selector) |
| msg_addr | output | 24 | Captured address or register number |
| pay_valid | output | 1 | One-cycle strobe per payload byte |
| pay_byte | output | 8 | Payload byte |
| pay_count | output | 9 | 1-based ordinal of the current payload byte |
| frame_ok | output | 1 | One-cycle pulse: frame accepted |
| frame_bad | output | 1 | One-cycle pulse: frame dropped |

## Verification
The end of one frame and the start of the next can fall in the same cycle. The final byte's verdict pulse is being registered in the very cycle the next frame's start marker is accepted. The bench provokes this by streaming frames with no idle cycle between them, including a failed frame followed immediately by a good one. A scoreboard fed by the driver expects the verdict pulse, then the new frame's strobes in order, with the correct type and address. A lost start marker or a stray strobe shows up as a missing or unexpected event.

// File: rtl/cfr_pkg.sv
package cfr_pkg;

    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned ADDR_BYTES = 3;

    localparam logic [BYTE_W-1:0] MARK_START = 8'h3C;
    localparam logic [BYTE_W-1:0] MARK_END   = 8'hA5;
    localparam logic [BYTE_W-1:0] CRC_POLY   = 8'h07;
    localparam logic [BYTE_W-1:0] CRC_SEED   = 8'h00;

    typedef enum logic [2:0] {
        PH_HUNT,
        PH_KIND,
        PH_SIZE,
        PH_ADDR,
        PH_DATA,
        PH_CHECK,
        PH_TAIL
    } phase_e;

endpackage

// File: rtl/cfr_crc_step.sv
module cfr_crc_step #(
    parameter int unsigned        W    = 8,
    parameter logic [W-1:0]       POLY = 8'h07
) (
    input  logic [W-1:0] crc_in,
    input  logic [W-1:0] data_in,
    output logic [W-1:0] crc_out
);

    logic [W-1:0] chain [0:W];

    assign chain[0] = crc_in ^ data_in;

    for (genvar g = 0; g < W; g++) begin : g_bit
        assign chain[g+1] = chain[g][W-1] ? ({chain[g][W-2:0], 1'b0} ^ POLY)
                                          :  {chain[g][W-2:0], 1'b0};
    end

    assign crc_out = chain[W];

endmodule

// File: rtl/cfr_burst_ctr.sv
module cfr_burst_ctr #(
    parameter int unsigned LEN_W = 8,
    localparam int unsigned CNT_W = LEN_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_len,
    input  logic             step,
    output logic             last,
    output logic [CNT_W-1:0] ordinal
);

    typedef struct packed {
        logic [LEN_W-1:0] remain;
        logic [CNT_W-1:0] ord;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (load) begin
            ctr_d.remain = load_len;
            ctr_d.ord    = '0;
        end else if (step) begin
            if (ctr_q.remain != '0) begin
                ctr_d.remain = ctr_q.remain - 1'b1;
            end
            ctr_d.ord = ctr_q.ord + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_q <= '0;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign last    = (ctr_q.remain == '0);
    assign ordinal = ctr_q.ord;

    AST_ORD_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        ctr_q.ord <= CNT_W'(2**LEN_W)); // R4

    AST_ORD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (ctr_q.ord == '0)); // R4

endmodule

// File: rtl/cfr_frame_rx.sv
module cfr_frame_rx
    import cfr_pkg::*;
#(
    parameter int unsigned W      = BYTE_W,
    parameter int unsigned NADDR  = ADDR_BYTES,
    localparam int unsigned ADDR_W = NADDR * W,
    localparam int unsigned CNT_W  = W + 1,
    localparam int unsigned IDX_W  = (NADDR > 1) ? $clog2(NADDR) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [W-1:0]      in_byte,
    output logic [W-1:0]      msg_kind,
    output logic [ADDR_W-1:0] msg_addr,
    output logic              pay_valid,
    output logic [W-1:0]      pay_byte,
    output logic [CNT_W-1:0]  pay_count,
    output logic              frame_ok,
    output logic              frame_bad
);

    typedef struct packed {
        phase_e            phase;
        logic [IDX_W-1:0]  aidx;
        logic [W-1:0]      kind;
        logic [ADDR_W-1:0] addr;
        logic [W-1:0]      crc;
        logic              pv;
        logic [W-1:0]      pb;
        logic              ok;
        logic              bad;
    } rx_t;

    rx_t rx_d, rx_q;

    logic [W-1:0] crc_base;
    logic [W-1:0] crc_next;
    logic         ctr_load;
    logic         ctr_step;
    logic         ctr_last;
    logic [CNT_W-1:0] ctr_ord;

    assign crc_base = (rx_q.phase == PH_KIND) ? W'(CRC_SEED) : rx_q.crc;

    cfr_crc_step #(
        .W    (W),
        .POLY (W'(CRC_POLY))
    ) u_crc (
        .crc_in  (crc_base),
        .data_in (in_byte),
        .crc_out (crc_next)
    );

    cfr_burst_ctr #(
        .LEN_W (W)
    ) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctr_load),
        .load_len (in_byte),
        .step     (ctr_step),
        .last     (ctr_last),
        .ordinal  (ctr_ord)
    );

    always_comb begin
        rx_d     = rx_q;
        rx_d.pv  = 1'b0;
        rx_d.ok  = 1'b0;
        rx_d.bad = 1'b0;
        ctr_load = 1'b0;
        ctr_step = 1'b0;
        if (in_valid) begin
            unique case (rx_q.phase)
                PH_HUNT: begin
                    if (in_byte == W'(MARK_START)) begin
                        rx_d.phase = PH_KIND;
                    end
                end
                PH_KIND: begin
                    rx_d.kind  = in_byte;
                    rx_d.crc   = crc_next;
                    rx_d.phase = PH_SIZE;
                end
                PH_SIZE: begin
                    rx_d.crc   = crc_next;
                    rx_d.aidx  = '0;
                    ctr_load   = 1'b1;
                    rx_d.phase = PH_ADDR;
                end
                PH_ADDR: begin
                    rx_d.crc  = crc_next;
                    rx_d.addr = {rx_q.addr[ADDR_W-W-1:0], in_byte};
                    rx_d.aidx = rx_q.aidx + 1'b1;
                    if (rx_q.aidx == IDX_W'(NADDR - 1)) begin
                        rx_d.phase = PH_DATA;
                    end
                end
                PH_DATA: begin
                    rx_d.crc = crc_next;
                    rx_d.pv  = 1'b1;
                    rx_d.pb  = in_byte;
                    ctr_step = 1'b1;
                    if (ctr_last) begin
                        rx_d.phase = PH_CHECK;
                    end
                end
                PH_CHECK: begin
                    if (in_byte == rx_q.crc) begin
                        rx_d.phase = PH_TAIL;
                    end else begin
                        rx_d.bad   = 1'b1;
                        rx_d.phase = PH_HUNT;
                    end
                end
                PH_TAIL: begin
                    if (in_byte == W'(MARK_END)) begin
                        rx_d.ok = 1'b1;
                    end else begin
                        rx_d.bad = 1'b1;
                    end
                    rx_d.phase = PH_HUNT;
                end
                default: begin
                    rx_d.phase = PH_HUNT;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q       <= '0;
            rx_q.phase <= PH_HUNT;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign msg_kind  = rx_q.kind;
    assign msg_addr  = rx_q.addr;
    assign pay_valid = rx_q.pv;
    assign pay_byte  = rx_q.pb;
    assign pay_count = ctr_ord;
    assign frame_ok  = rx_q.ok;
    assign frame_bad = rx_q.bad;

    AST_HUNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_q.phase == PH_HUNT && in_valid && in_byte != W'(MARK_START))
        |=> (rx_q.phase == PH_HUNT && !pay_valid && !frame_ok && !frame_bad)); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> !(pay_valid || frame_ok || frame_bad)); // R8

    AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_ok && frame_bad) && !(pay_valid && (frame_ok || frame_bad))); // R9

    AST_OK_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ok |-> $past(in_valid && in_byte == W'(MARK_END))); // R5

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pay_valid && $past(pay_valid)) |-> (pay_count == $past(pay_count) + 1'b1)); // R4

    AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        pay_valid |-> (pay_count != '0)); // R4

endmodule

// File: tb/tb_cfr_frame_rx.sv
`timescale 1ns/1ps
module tb_cfr_frame_rx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic [7:0]  msg_kind;
    logic [23:0] msg_addr;
    logic        pay_valid;
    logic [7:0]  pay_byte;
    logic [8:0]  pay_count;
    logic        frame_ok;
    logic        frame_bad;

    always #2.5 clk = ~clk;

    cfr_frame_rx dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_byte   (in_byte),
        .msg_kind  (msg_kind),
        .msg_addr  (msg_addr),
        .pay_valid (pay_valid),
        .pay_byte  (pay_byte),
        .pay_count (pay_count),
        .frame_ok  (frame_ok),
        .frame_bad (frame_bad)
    );

    typedef struct {
        int          kind;   // 0 payload, 1 ok, 2 bad
        logic [7:0]  b;
        int          cnt;
        logic [7:0]  ty;
        logic [23:0] ad;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    bit   finished = 1'b0;
    logic [7:0] pay_buf [0:255];

    function automatic logic [7:0] crc_upd(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] x;
        x = c ^ d;
        for (int i = 0; i < 8; i++) begin
            x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
        end
        return x;
    endfunction

    task automatic check(input bit cond, input string tag, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_byte  = 8'h00;
        end
    endtask

    // mode: 0 good, 1 bad check byte, 2 bad end byte
    task automatic send_frame(input logic [7:0] ty, input logic [23:0] ad,
                              input logic [7:0] len, input int seed,
                              input int mode, input bit gaps, input string tag);
        logic [7:0] c;
        exp_t e;
        int   nb;
        nb = int'(len) + 1;
        for (int i = 0; i < nb; i++) begin
            pay_buf[i] = 8'((seed * 7 + i * 13) & 8'hFF);
        end
        c = 8'h00;
        c = crc_upd(c, ty);
        c = crc_upd(c, len);
        c = crc_upd(c, ad[23:16]);
        c = crc_upd(c, ad[15:8]);
        c = crc_upd(c, ad[7:0]);
        put(8'h3C); if (gaps) idle(1);
        put(ty);    if (gaps) idle(2);
        put(len);   if (gaps) idle(1);
        put(ad[23:16]); put(ad[15:8]); if (gaps) idle(1);
        put(ad[7:0]);
        for (int i = 0; i < nb; i++) begin
            e.kind = 0; e.b = pay_buf[i]; e.cnt = i + 1; e.ty = ty; e.ad = ad;
            e.tag = (gaps) ? "R8" : "R4";
            exp_q.push_back(e);
            put(pay_buf[i]);
            c = crc_upd(c, pay_buf[i]);
            if (gaps && (i % 2 == 0)) idle(1);
        end
        if (mode == 1) begin
            e.kind = 2; e.b = 0; e.cnt = nb; e.ty = ty; e.ad = ad; e.tag = "R6";
            exp_q.push_back(e);
            put(c ^ 8'h01);
            put(8'hA5);  // R6: must be ignored after the drop
        end else begin
            put(c);
            if (gaps) idle(1);
            if (mode == 2) begin
                e.kind = 2; e.tag = "R7";
            end else begin
                e.kind = 1; e.tag = tag;
            end
            e.b = 0; e.cnt = nb; e.ty = ty; e.ad = ad;
            exp_q.push_back(e);
            put((mode == 2) ? 8'h5A : 8'hA5);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (frame_ok && frame_bad) begin
                check(1'b0, "R9", "ok and bad together", 1, 0);
            end
            if (pay_valid && (frame_ok || frame_bad)) begin
                check(1'b0, "R9", "strobe with verdict", 1, 0);
            end
            if (pay_valid || frame_ok || frame_bad) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2", "unexpected event", int'({pay_valid, frame_ok, frame_bad}), 0);
                end else begin
                    exp_t e;
                    int   got;
                    e = exp_q.pop_front();
                    got = pay_valid ? 0 : (frame_ok ? 1 : 2);
                    check(got == e.kind, e.tag, "event kind", got, e.kind);
                    if (got == 0 && e.kind == 0) begin
                        check(pay_byte == e.b, e.tag, "payload byte", int'(pay_byte), int'(e.b));
                        check(int'(pay_count) == e.cnt, e.tag, "payload ordinal", int'(pay_count), e.cnt);
                    end
                    if (got == 1 && e.kind == 1) begin
                        check(msg_kind == e.ty, "R3", "type", int'(msg_kind), int'(e.ty));
                        check(msg_addr == e.ad, "R3", "address", int'(msg_addr), int'(e.ad));
                        check(int'(pay_count) == e.cnt, "R4", "final count", int'(pay_count), e.cnt);
                    end
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        // R1: reset state
        check(msg_kind == 8'h00 && msg_addr == 24'h0, "R1", "fields after reset",
              int'(msg_addr), 0);
        check(!pay_valid && !frame_ok && !frame_bad && pay_count == 9'd0 && pay_byte == 8'h00,
              "R1", "strobes after reset", int'({pay_valid, frame_ok, frame_bad}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        check(msg_kind == 8'h00 && !pay_valid, "R1", "idle after release", int'(msg_kind), 0);

        // R2: garbage while hunting, including end marker and check-like bytes
        put(8'hA5); put(8'h00); put(8'hFF); put(8'h3B); put(8'h3D); put(8'h11);
        idle(2);
        check(msg_kind == 8'h00 && msg_addr == 24'h0, "R2", "fields untouched by noise",
              int'(msg_addr), 0);

        // R3 R4 R5: single-byte payload
        send_frame(8'h11, 24'h123456, 8'h00, 1, 0, 1'b0, "R5");
        idle(3);
        check(msg_addr == 24'h123456, "R3", "address held", int'(msg_addr), 24'h123456);

        // R4: maximum burst
        send_frame(8'h3C, 24'hA5003C, 8'hFF, 5, 0, 1'b0, "R5");
        idle(2);

        // R8: gaps inside a frame
        send_frame(8'h42, 24'h00FF01, 8'h04, 9, 0, 1'b1, "R8");
        idle(2);

        // R6: bad check byte, trailing 0xA5 ignored
        send_frame(8'h07, 24'h0A0B0C, 8'h02, 3, 1, 1'b0, "R6");
        idle(2);
        check(exp_q.size() == 0, "R6", "pending after drop", exp_q.size(), 0);

        // R7: bad end byte
        send_frame(8'h08, 24'h111111, 8'h01, 4, 2, 1'b0, "R7");
        idle(2);

        // R10: back-to-back, failed frame followed at once by good ones
        send_frame(8'h21, 24'h010203, 8'h02, 6, 2, 1'b0, "R10");
        send_frame(8'h22, 24'h040506, 8'h03, 7, 0, 1'b0, "R10");
        send_frame(8'h23, 24'h070809, 8'h00, 8, 0, 1'b0, "R10");
        idle(4);
        check(msg_kind == 8'h23 && msg_addr == 24'h070809, "R10", "last frame fields",
              int'(msg_addr), 24'h070809);

        check(exp_q.size() == 0, "R5", "all expected events seen", exp_q.size(), 0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule